// File: doc/BRIEF.md
# Receive-Only I2C Target with Strap-Selected Address

This block is a bus target that only ever accepts writes. It watches the two-wire bus lines, sampled into the system clock domain. It recognises START and STOP conditions and shifts in the first byte of each transfer, most significant bit first. It claims that byte only when two conditions hold. The seven address bits must equal a fixed six-bit prefix followed by the level of a strap pin. The direction bit must request a write. Once claimed, every later byte of the transfer is acknowledged. Each byte is handed to a downstream consumer as an 8-bit word with a one-cycle strobe.

The block never places data on the bus. Its only drive is an open-drain pull-down enable, which is active during acknowledge bits. A read request, even to its own address, gets no acknowledge. It also gets no acknowledge for a foreign address. In both cases the target stays silent until the next START. Pulses at the outputs report START, STOP and the close of a claimed transfer.

Top module: `i2c_sink_slave`

## Requirements
- R1: While reset is held and directly after it, the pull-down enable, the byte strobe and all three event pulses are 0.
- R2: A falling SDA with SCL high gives a one-cycle pulse on `start_o`. A rising SDA with SCL high gives a one-cycle pulse on `stop_o`. The two never pulse together.
- R3: A first byte whose upper seven bits are 0111100 or 0111101 claims the transfer, provided bit 0 (the direction bit, 0 = write) is 0 and the last address bit equals `strap_i`. SDA is then pulled low throughout the ninth clock.
- R4: An address whose last bit differs from `strap_i` is not acknowledged.
- R5: A first byte with the direction bit at 1 is not acknowledged, even when the seven address bits match.
- R6: After a claimed address, each further byte of the transfer is acknowledged in its ninth clock.
- R7: Each byte after a claimed address appears on `rx_data_o`, first received bit in bit 7, together with a one-cycle `rx_valid_o` pulse after its eighth bit.
- R8: After an unclaimed address, there is no acknowledge and no byte strobe until the next START.
- R9: A repeated START in the middle of a byte discards the partial byte and begins address matching anew.
- R10: A STOP that closes a claimed transfer gives a one-cycle `xfer_end_o` pulse one cycle after `stop_o`. A STOP after an unclaimed transfer gives none.
- R11: The pull-down enable is never active while data bits are being received. It changes only after a falling SCL, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 1 | Static level that sets the last address bit |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| start_o | output | 1 | START seen |
| stop_o | output | 1 | STOP seen |
| xfer_end_o | output | 1 | STOP closed a claimed transfer |

## Verification
The assertions assume the bus follows the protocol. SDA may change only while SCL is low, apart from START and STOP. SCL phases must last longer than the synchroniser delay. The strap must be static within a transfer. The bench's bus master drives SDA in the middle of the SCL-low phase. Each SCL phase is held for ten system cycles, well beyond the three-cycle path through the synchroniser and edge detector. The strap is changed only between transfers, while the bus is idle. The bench models the line as open drain, combining the master's level with the target's pull-down, so that acknowledges are seen at the wire.

// File: rtl/i2c_sink_pkg.sv
package i2c_sink_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_DATA,
      ST_SKIP
   } rx_state_e;
endpackage

// File: rtl/i2c_sink_sync.sv
module i2c_sink_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_sink_cond.sv
module i2c_sink_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_evt,
   output logic stop_evt,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
endmodule

// File: rtl/i2c_sink_fsm.sv
module i2c_sink_fsm
   import i2c_sink_pkg::*;
#(
   parameter int                ADDR_W     = 7,
   parameter logic [ADDR_W-2:0] ADDR_FIXED = 6'b011110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              strap_i,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              scl_rise,
   input  logic              scl_fall,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              xfer_end,
   output logic              selected,
   output logic              ack_phase
);
   rx_state_e         st;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  bitcnt;
   logic              addr_ok;

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

   assign addr_ok = (shreg[BYTE_W-1:1] == {ADDR_FIXED, strap_i}) && !shreg[0];
   assign ack_phase = (st == ST_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         shreg    <= '0;
         bitcnt   <= '0;
         sda_oe   <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         xfer_end <= 1'b0;
         selected <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         xfer_end <= 1'b0;
         if (start_evt) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            sda_oe   <= 1'b0;
            selected <= 1'b0;
         end else if (stop_evt) begin
            st       <= ST_IDLE;
            sda_oe   <= 1'b0;
            xfer_end <= selected;
            selected <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL) begin
                     if (addr_ok) begin
                        sda_oe   <= 1'b1;
                        selected <= 1'b1;
                        st       <= ST_ACK;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_DATA: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                     if (bitcnt == LAST_BIT) begin
                        rx_data  <= {shreg[BYTE_W-2:0], sda_s};
                        rx_valid <= 1'b1;
                     end
                  end else if (scl_fall && bitcnt == FULL) begin
                     sda_oe <= 1'b1;
                     st     <= ST_ACK;
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     st     <= ST_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_sink_slave.sv
module i2c_sink_slave
   import i2c_sink_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-2:0] ADDR_FIXED  = 6'b011110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              strap_i,
   output logic              sda_oe_o,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   output logic              start_o,
   output logic              stop_o,
   output logic              xfer_end_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W + 1 != BYTE_W) begin : g_bad_addr
         $error("address plus direction bit must fill one byte");
      end
   endgenerate

   logic scl_s, sda_s;
   logic start_evt, stop_evt, scl_rise, scl_fall;
   logic selected, ack_phase;

   i2c_sink_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   i2c_sink_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2c_sink_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .scl_rise(scl_rise), .scl_fall(scl_fall));

   i2c_sink_fsm #(.ADDR_W(ADDR_W), .ADDR_FIXED(ADDR_FIXED)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .strap_i(strap_i),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_oe(sda_oe_o), .rx_data(rx_data_o), .rx_valid(rx_valid_o),
      .xfer_end(xfer_end_o), .selected(selected), .ack_phase(ack_phase));

   assign start_o = start_evt;
   assign stop_o  = stop_evt;
endmodule

// File: rtl/i2c_sink_chk.sv
module i2c_sink_chk (
   input logic clk,
   input logic rst_n,
   input logic start_o,
   input logic stop_o,
   input logic rx_valid_o,
   input logic sda_oe_o,
   input logic xfer_end_o,
   input logic scl_fall,
   input logic selected,
   input logic ack_phase
);
   AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && stop_o)); // R2

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o); // R7

   AST_VALID_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> selected); // R8

   AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> selected); // R3

   AST_OE_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe_o |-> ack_phase); // R11

   AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_fall && !start_o && !stop_o) |=> $stable(sda_oe_o)); // R11

   AST_END_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end_o |-> $past(stop_o)); // R10
endmodule

bind i2c_sink_slave i2c_sink_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_o(start_o), .stop_o(stop_o),
   .rx_valid_o(rx_valid_o), .sda_oe_o(sda_oe_o), .xfer_end_o(xfer_end_o),
   .scl_fall(scl_fall), .selected(selected), .ack_phase(ack_phase));

// File: tb/i2c_sink_slave_test.sv
module i2c_sink_slave_test;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
   logic sda_oe;
   logic [7:0] rx_data;
   logic rx_valid, start_p, stop_p, xend_p;
   logic sda_line;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_sink_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .strap_i(strap), .sda_oe_o(sda_oe), .rx_data_o(rx_data),
      .rx_valid_o(rx_valid), .start_o(start_p), .stop_o(stop_p),
      .xfer_end_o(xend_p));

   int n_chk = 0, n_fail = 0;
   int n_valid = 0, n_start = 0, n_stop = 0, n_xend = 0, n_leak = 0;
   logic [7:0] cap [0:31];
   bit done = 0;

   always @(negedge clk) begin
      if (rx_valid) begin
         cap[n_valid % 32] <= rx_data;
         n_valid <= n_valid + 1;
      end
      if (start_p) n_start <= n_start + 1;
      if (stop_p)  n_stop  <= n_stop + 1;
      if (xend_p)  n_xend  <= n_xend + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hold(Q);
      scl_m = 1'b1; hold(Q);
      sda_m = 1'b0; hold(Q);
      scl_m = 1'b0; hold(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold(Q);
      scl_m = 1'b1; hold(Q);
      sda_m = 1'b1; hold(2 * Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         sda_m = b[i]; hold(Q / 2);
         scl_m = 1'b1; hold(Q / 2);
         if (sda_oe) n_leak++;
         hold(Q / 2);
         scl_m = 1'b0; hold(Q / 2);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_m = 1'b1; hold(Q / 2);
      scl_m = 1'b1; hold(Q / 2);
      ack = !sda_line;
      hold(Q / 2);
      scl_m = 1'b0; hold(Q / 2);
   endtask

   // {strap, addr7, rw, data, expect_ack}
   localparam int NV = 8;
   localparam logic [17:0] VEC [NV] = '{
      {1'b0, 7'h3C, 1'b0, 8'hA5, 1'b1},
      {1'b1, 7'h3D, 1'b0, 8'h3C, 1'b1},
      {1'b0, 7'h3D, 1'b0, 8'hFF, 1'b0},
      {1'b1, 7'h3C, 1'b0, 8'h00, 1'b0},
      {1'b0, 7'h3C, 1'b1, 8'h55, 1'b0},
      {1'b0, 7'h12, 1'b0, 8'h81, 1'b0},
      {1'b1, 7'h3D, 1'b1, 8'h11, 1'b0},
      {1'b0, 7'h3C, 1'b0, 8'h01, 1'b1}
   };

   initial begin
      bit ack;
      int v0, s0, p0, e0;
      hold(3);
      // R1: reset state
      chk(!sda_oe && !rx_valid && !start_p && !stop_p && !xend_p, "R1 during reset",
          {sda_oe, rx_valid, start_p, stop_p, xend_p}, 0);
      rst_n = 1'b1;
      hold(5);
      chk(!sda_oe && !rx_valid && !start_p && !stop_p && !xend_p, "R1 after reset",
          {sda_oe, rx_valid, start_p, stop_p, xend_p}, 0);

      for (int k = 0; k < NV; k++) begin
         logic [17:0] e;
         e = VEC[k];
         strap = e[17];
         hold(Q);
         v0 = n_valid; s0 = n_start; p0 = n_stop; e0 = n_xend;
         bus_start();
         send_byte({e[16:10], e[9]}, ack);
         chk(ack == e[0], "R3/R4/R5 address ack", ack, e[0]);
         send_byte(e[8:1], ack);
         chk(ack == e[0], "R6/R8 data ack byte 0", ack, e[0]);
         send_byte(~e[8:1], ack);
         chk(ack == e[0], "R6/R8 data ack byte 1", ack, e[0]);
         bus_stop();
         chk(n_start - s0 == 1, "R2 start pulse", n_start - s0, 1);
         chk(n_stop - p0 == 1, "R2 stop pulse", n_stop - p0, 1);
         chk(n_valid - v0 == (e[0] ? 2 : 0), "R7/R8 strobe count", n_valid - v0, e[0] ? 2 : 0);
         if (e[0]) begin
            chk(cap[v0 % 32] == e[8:1], "R7 byte 0 value", cap[v0 % 32], e[8:1]);
            chk(cap[(v0 + 1) % 32] == ~e[8:1], "R7 byte 1 value", cap[(v0 + 1) % 32], ~e[8:1]);
         end
         chk(n_xend - e0 == int'(e[0]), "R10 end pulse", n_xend - e0, e[0]);
      end
      chk(n_leak == 0, "R11 no pull-down during data bits", n_leak, 0);

      // R9: repeated start in the middle of a data byte
      strap = 1'b0; hold(Q);
      v0 = n_valid; e0 = n_xend;
      bus_start();
      send_byte(8'h78, ack);
      chk(ack, "R9 first address ack", ack, 1);
      send_bits(8'hF0, 4);
      bus_start();
      send_byte(8'h78, ack);
      chk(ack, "R9 re-address ack", ack, 1);
      send_byte(8'h5A, ack);
      chk(ack, "R9 data ack after restart", ack, 1);
      bus_stop();
      chk(n_valid - v0 == 1, "R9 partial byte discarded", n_valid - v0, 1);
      chk(cap[v0 % 32] == 8'h5A, "R9 byte after restart", cap[v0 % 32], 8'h5A);
      chk(n_xend - e0 == 1, "R10 end after restart", n_xend - e0, 1);

      // R8/R9: foreign address, then repeated start to own address
      strap = 1'b1; hold(Q);
      v0 = n_valid;
      bus_start();
      send_byte(8'h40, ack);
      chk(!ack, "R8 foreign address not acked", ack, 0);
      send_byte(8'h7B, ack);
      chk(!ack, "R8 byte ignored after foreign address", ack, 0);
      chk(n_valid == v0, "R8 no strobe while ignoring", n_valid - v0, 0);
      bus_start();
      send_byte(8'h7A, ack);
      chk(ack, "R9 matching resumes after restart", ack, 1);
      send_byte(8'hC3, ack);
      chk(ack, "R6 data ack", ack, 1);
      bus_stop();
      chk(n_valid - v0 == 1 && cap[v0 % 32] == 8'hC3, "R7 byte value", cap[v0 % 32], 8'hC3);
      chk(n_leak == 0, "R11 no pull-down during data bits", n_leak, 0);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule